// File: doc/BRIEF.md
# Double-Buffered Channel Compare Register

This block holds the 16-bit compare value of one timer channel. Software delivers the value one byte at a time over a small write port, choosing the high or the low byte on each transfer. The bytes collect in a staging buffer. The value that the channel logic actually compares against is a separate active register. The block copies the buffer into the active register only at a moment that depends on the channel mode and on whether the timer clock is running. This lets software change a compare value at any time without creating a glitched period.

The block has no counter of its own. It watches the timer count and the modulo limit, and it compares each cycle's count with the count it recorded on the previous cycle. From that comparison it detects three things: a change in the count, a wrap to zero, and a turnaround below the modulo limit. A counter event counts only while the clock-select field is non-zero. Reads of the register return the active value, which the block drives on `cmp_value`.

The write port uses a valid/ready handshake. The block never applies back-pressure: `wr_ready` is high in every cycle, so each cycle with `wr_valid` high transfers exactly one byte.

Top module: `cmp_value_buffer`

## Requirements
- R1: After reset, `cmp_value` is 0x0000, `load_pending` is low and the staging buffer holds 0x0000.
- R2: With `clk_sel` = 00 (timer stopped), the cycle that completes a byte pair loads the active register. This holds whether the high byte or the low byte arrives last. The new value appears on `cmp_value` in the next cycle and `load_pending` stays low.
- R3: A single byte write (`wr_hi` = 1 selects bits 15:8, `wr_hi` = 0 selects bits 7:0) never changes `cmp_value` and never raises `load_pending`. Both bytes are needed, in either order.
- R4: With the clock running and `mode` = 00 (output compare; the value 11 behaves the same way), a completed pair raises `load_pending`. The load happens on the first cycle after the pair-completing write in which `cnt` differs from its value in the previous cycle. A change of the count in the same cycle as the completing write does not cause the load.
- R5: With the clock running and `mode` = 01 (edge-aligned PWM), a pending value loads only in the cycle where `cnt` goes from `modulo` to 0x0000.
- R6: In edge-aligned PWM with `free_run` = 1, the load point is `cnt` going from 0xFFFF to 0x0000. A step from `modulo` to 0x0000 does not load.
- R7: With the clock running and `mode` = 10 (center-aligned PWM), a pending value loads only in the cycle where `cnt` goes from `modulo` to `modulo` − 1.
- R8: A byte written while a load is pending replaces that byte of the buffer. If the byte arrives in the load cycle, the load still takes the newest byte. A load clears `load_pending`. `load_pending` rises again only after a further complete high/low pair.
- R9: `wr_ready` is high in every cycle, including during reset. Every cycle with `wr_valid` high accepts one byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Byte write request |
| wr_ready | output | 1 | Write accepted (always high) |
| wr_hi | input | 1 | 1 = high byte, 0 = low byte |
| wr_data | input | 8 | Byte to write |
| cnt | input | 16 | Current timer count |
| modulo | input | 16 | Timer modulo limit |
| free_run | input | 1 | Counter wraps at 0xFFFF rather than at modulo |
| mode | input | 2 | 00 output compare, 01 edge PWM, 10 center PWM, 11 as 00 |
| clk_sel | input | 2 | Timer clock select, 00 = stopped |
| cmp_value | output | 16 | Active compare value (register read data) |
| load_pending | output | 1 | A complete pair waits for its load point |

## Verification
The two functions that can coincide are a byte write into the staging buffer and the transfer of that buffer into the active register. The bench provokes this in edge-aligned PWM by writing the second byte in the same cycle that the count wraps from the modulo limit to zero. It judges the result by checking that the active value holds the fresh byte and that `load_pending` falls rather than re-arming. A second coincidence is provoked in output compare mode, where the completing write lands in the same cycle as a count change. In that case the load must wait for the next change.

// File: rtl/cvb_pkg.sv
package cvb_pkg;
  typedef enum logic [1:0] {
    MODE_OC   = 2'b00,
    MODE_EPWM = 2'b01,
    MODE_CPWM = 2'b10,
    MODE_RSVD = 2'b11
  } chan_mode_e;
endpackage

// File: rtl/cvb_write_stage.sv
// Staging buffer: byte lanes, pair tracking and the pending flag.
module cvb_write_stage #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_fire,
  input  logic                wr_hi,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic                load,
  output logic [2*BYTE_W-1:0] buf_next,
  output logic                pair_done,
  output logic                pending_q
);
  localparam int LANES = 2;
  localparam int VAL_W = LANES * BYTE_W;

  logic [VAL_W-1:0] buf_q;
  logic [LANES-1:0] got_q;
  logic [LANES-1:0] got_next;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      logic hit;
      assign hit = wr_fire && (wr_hi == 1'(g));
      assign buf_next[g*BYTE_W +: BYTE_W] = hit ? wr_data : buf_q[g*BYTE_W +: BYTE_W];
      assign got_next[g] = got_q[g] | hit;
    end
  endgenerate

  assign pair_done = &got_next;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q     <= '0;
      got_q     <= '0;
      pending_q <= 1'b0;
    end else begin
      buf_q     <= buf_next;
      got_q     <= pair_done ? '0 : got_next;
      pending_q <= (pending_q | pair_done) & ~load;
    end
  end

  // A lone byte with nothing pending must not arm a load.
  AST_HALF_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !pair_done && !pending_q) |=> !pending_q); // R3
endmodule

// File: rtl/cvb_event_detect.sv
// Detects count change, wrap and turnaround from previous/current count.
module cvb_event_detect
  import cvb_pkg::*;
#(
  parameter int VAL_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VAL_W-1:0] cnt,
  input  logic [VAL_W-1:0] modulo,
  input  logic             free_run,
  input  logic [1:0]       mode,
  input  logic [1:0]       clk_sel,
  output logic             clk_on,
  output logic             evt
);
  logic [VAL_W-1:0] prev_q;
  logic [VAL_W-1:0] wrap_top;
  logic [VAL_W-1:0] mod_m1;
  logic             moved, wrapped, turned, raw;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cnt;
  end

  assign clk_on   = (clk_sel != 2'b00);
  assign wrap_top = free_run ? '1 : modulo;
  assign mod_m1   = modulo - 1'b1;
  assign moved    = (cnt != prev_q);
  assign wrapped  = (prev_q == wrap_top) && (cnt == '0);
  assign turned   = (prev_q == modulo) && (cnt == mod_m1);

  always_comb begin
    case (chan_mode_e'(mode))
      MODE_EPWM: raw = wrapped;
      MODE_CPWM: raw = turned;
      default:   raw = moved;
    endcase
  end

  assign evt = clk_on && raw;
endmodule

// File: rtl/cmp_value_buffer.sv
module cmp_value_buffer
  import cvb_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic                wr_hi,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic [2*BYTE_W-1:0] cnt,
  input  logic [2*BYTE_W-1:0] modulo,
  input  logic                free_run,
  input  logic [1:0]          mode,
  input  logic [1:0]          clk_sel,
  output logic [2*BYTE_W-1:0] cmp_value,
  output logic                load_pending
);
  localparam int VAL_W = 2 * BYTE_W;

  logic [VAL_W-1:0] buf_next;
  logic [VAL_W-1:0] active_q;
  logic             pair_done, pending_q, clk_on, evt, load, wr_fire;

  assign wr_ready = 1'b1;
  assign wr_fire  = wr_valid && wr_ready;

  cvb_write_stage #(.BYTE_W(BYTE_W)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_fire   (wr_fire),
    .wr_hi     (wr_hi),
    .wr_data   (wr_data),
    .load      (load),
    .buf_next  (buf_next),
    .pair_done (pair_done),
    .pending_q (pending_q)
  );

  cvb_event_detect #(.VAL_W(VAL_W)) u_evt (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt      (cnt),
    .modulo   (modulo),
    .free_run (free_run),
    .mode     (mode),
    .clk_sel  (clk_sel),
    .clk_on   (clk_on),
    .evt      (evt)
  );

  // Stopped clock: load as soon as a pair is complete.
  // Running clock: only an already-registered pending pair meets the event.
  assign load = clk_on ? (pending_q && evt) : (pending_q || pair_done);

  always_ff @(posedge clk) begin
    if (!rst_n)    active_q <= '0;
    else if (load) active_q <= buf_next;
  end

  assign cmp_value    = active_q;
  assign load_pending = pending_q;

  logic [VAL_W-1:0] cnt_p1;
  assign cnt_p1 = cnt + 1'b1;

  AST_STOP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_on && pair_done) |=> (cmp_value == $past(buf_next)) && !load_pending); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_pending && !pair_done) |=> $stable(cmp_value)); // R3
  AST_EPWM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (load && clk_on && chan_mode_e'(mode) == MODE_EPWM) |-> (cnt == '0)); // R5
  AST_CPWM_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (load && clk_on && chan_mode_e'(mode) == MODE_CPWM) |-> (cnt_p1 == modulo)); // R7
  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !load_pending); // R8
endmodule

// File: tb/test_cmp_value_buffer.sv
module test_cmp_value_buffer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0, wr_hi = 1'b0, free_run = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [15:0] cnt = '0, modulo = 16'd10;
  logic [1:0]  mode = 2'b00, clk_sel = 2'b00;
  logic        wr_ready, load_pending;
  logic [15:0] cmp_value;

  int    checks = 0, errors = 0;
  bit    done = 1'b0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  cmp_value_buffer i_cmp_value_buffer (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_hi(wr_hi), .wr_data(wr_data), .cnt(cnt), .modulo(modulo),
    .free_run(free_run), .mode(mode), .clk_sel(clk_sel),
    .cmp_value(cmp_value), .load_pending(load_pending)
  );

  // Behavioural reference, advanced on every rising edge.
  logic [15:0] m_buf = '0, m_act = '0, m_prev = '0;
  bit          m_hi = 0, m_lo = 0, m_pend = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_buf = '0; m_act = '0; m_prev = '0; m_hi = 0; m_lo = 0; m_pend = 0;
    end else begin
      logic [15:0] nb, top;
      bit nh, nl, pair, on, ev, ld;
      nb = m_buf; nh = m_hi; nl = m_lo;
      if (wr_valid) begin
        if (wr_hi) begin nb[15:8] = wr_data; nh = 1; end
        else       begin nb[7:0]  = wr_data; nl = 1; end
      end
      pair = nh && nl;
      on   = (clk_sel != 2'b00);
      top  = free_run ? 16'hFFFF : modulo;
      if (mode == 2'b01)      ev = (m_prev == top) && (cnt == 16'h0000);
      else if (mode == 2'b10) ev = (m_prev == modulo) && (cnt == 16'(modulo - 1));
      else                    ev = (cnt != m_prev);
      ld = on ? (m_pend && ev) : (m_pend || pair);
      if (ld) m_act = nb;
      m_pend = (m_pend || pair) && !ld;
      if (pair) begin m_hi = 0; m_lo = 0; end
      else begin m_hi = nh; m_lo = nl; end
      m_buf = nb; m_prev = cnt;
    end
    #1;
    if (!done) begin
      checks++;
      if (cmp_value !== m_act || load_pending !== m_pend || wr_ready !== 1'b1) begin
        errors++;
        $display("FAIL %s per-cycle: cmp=%h pend=%b rdy=%b expected cmp=%h pend=%b rdy=1",
                 cur_req, cmp_value, load_pending, wr_ready, m_act, m_pend);
      end
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One cycle of stimulus; returns just after the capturing edge.
  task automatic cyc(input bit w, input bit h, input logic [7:0] d, input logic [15:0] c);
    @(negedge clk);
    wr_valid = w; wr_hi = h; wr_data = d; cnt = c;
    @(posedge clk); #2;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", cmp_value, 16'h0000);
    chk("R1", {15'd0, load_pending}, 16'd0);
    chk("R9", {15'd0, wr_ready}, 16'd1);
    @(negedge clk); rst_n = 1'b1;

    cur_req = "R3"; clk_sel = 2'b00;
    cyc(1, 1, 8'h12, 0);
    chk("R3", cmp_value, 16'h0000);
    chk("R3", {15'd0, load_pending}, 16'd0);
    cur_req = "R2";
    cyc(1, 0, 8'h34, 0);
    chk("R2", cmp_value, 16'h1234);
    cyc(1, 0, 8'hCD, 0);
    cyc(1, 1, 8'hAB, 0);
    chk("R2", cmp_value, 16'hABCD);

    cur_req = "R3";
    cyc(1, 1, 8'h55, 0);
    repeat (3) cyc(0, 0, 0, 0);
    chk("R3", cmp_value, 16'hABCD);
    chk("R3", {15'd0, load_pending}, 16'd0);
    cyc(1, 0, 8'h66, 0);
    chk("R2", cmp_value, 16'h5566);

    cur_req = "R4";
    cyc(0, 0, 0, 100);
    clk_sel = 2'b01; mode = 2'b00;
    cyc(0, 0, 0, 100);
    cyc(1, 1, 8'h11, 100);
    cyc(1, 0, 8'h22, 100);
    chk("R4", {15'd0, load_pending}, 16'd1);
    repeat (3) cyc(0, 0, 0, 100);
    chk("R4", cmp_value, 16'h5566);
    cyc(0, 0, 0, 101);
    chk("R4", cmp_value, 16'h1122);
    cyc(1, 1, 8'h33, 101);
    cyc(1, 0, 8'h44, 102);
    chk("R4", cmp_value, 16'h1122);
    cyc(0, 0, 0, 103);
    chk("R4", cmp_value, 16'h3344);

    cur_req = "R5"; mode = 2'b01; modulo = 16'd10; free_run = 0;
    cyc(0, 0, 0, 3);
    cyc(1, 1, 8'h77, 3);
    cyc(1, 0, 8'h88, 3);
    for (int v = 4; v <= 10; v++) cyc(0, 0, 0, 16'(v));
    chk("R5", cmp_value, 16'h3344);
    cyc(0, 0, 0, 0);
    chk("R5", cmp_value, 16'h7788);

    cur_req = "R6"; free_run = 1;
    cyc(0, 0, 0, 10);
    cyc(1, 1, 8'h99, 10);
    cyc(1, 0, 8'hAA, 10);
    cyc(0, 0, 0, 0);
    chk("R6", cmp_value, 16'h7788);
    cyc(0, 0, 0, 16'hFFFE);
    cyc(0, 0, 0, 16'hFFFF);
    cyc(0, 0, 0, 0);
    chk("R6", cmp_value, 16'h99AA);

    cur_req = "R7"; free_run = 0; mode = 2'b10;
    cyc(0, 0, 0, 8);
    cyc(1, 1, 8'hBB, 8);
    cyc(1, 0, 8'hCC, 8);
    cyc(0, 0, 0, 9);
    cyc(0, 0, 0, 10);
    chk("R7", cmp_value, 16'h99AA);
    cyc(0, 0, 0, 9);
    chk("R7", cmp_value, 16'hBBCC);

    cur_req = "R8"; mode = 2'b01;
    cyc(0, 0, 0, 9);
    cyc(1, 1, 8'hDD, 9);
    cyc(1, 0, 8'hEE, 9);
    cyc(1, 1, 8'hF1, 9);
    chk("R8", cmp_value, 16'hBBCC);
    chk("R8", {15'd0, load_pending}, 16'd1);
    cyc(0, 0, 0, 10);
    cyc(1, 0, 8'h02, 0);
    chk("R8", cmp_value, 16'hF102);
    chk("R8", {15'd0, load_pending}, 16'd0);
    cyc(1, 1, 8'h03, 0);
    for (int v = 1; v <= 10; v++) cyc(0, 0, 0, 16'(v));
    cyc(0, 0, 0, 0);
    chk("R8", cmp_value, 16'hF102);
    cyc(1, 0, 8'h04, 0);
    chk("R8", {15'd0, load_pending}, 16'd1);
    for (int v = 1; v <= 10; v++) cyc(0, 0, 0, 16'(v));
    cyc(0, 0, 0, 0);
    chk("R8", cmp_value, 16'h0304);

    repeat (2) cyc(0, 0, 0, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule